// File: doc/BRIEF.md
# Bit-Slice Destination and Shifter Control

This block sits after the ALU of a narrow bit-slice datapath. A 3-bit destination code decides where the ALU result F goes. F can be written to the register-file word selected by the B address, loaded into the Q register, or shown on the Y bus. On the way into the register file, F can be shifted one place toward either end, and the Q register can be shifted the same way at the same time. The register file and the ALU live outside the block. This block produces the register-file write enable and write data, and it owns the Q register.

Each end of each shifter is a bidirectional pin when slices are cascaded. Here each pin is modelled as three signals: a separate input, an output value and an output enable. In a down-shift, the LSB-end port drives out the bit that is shifted off, and the MSB end takes its new bit from the neighbouring slice. In an up-shift, the roles of the two ends are swapped. In the non-shift codes, every port is high-impedance and its input is not used.

Top module: `dst_shift_ctrl`

## Requirements
- R1: Code 0 sets `q_load`, loads F into Q at the next rising edge, keeps `rf_we` low and drives Y with F.
- R2: Code 1 keeps both `rf_we` and `q_load` low, and Y shows F.
- R3: Code 2 raises `rf_we` with `rf_wdata` = F, holds Q and drives Y with `a_latch`.
- R4: Code 3 raises `rf_we` with `rf_wdata` = F and holds Q.
- R5: Codes 4 and 5 raise `rf_we` with `rf_wdata` = {`rf_hi_in`, F[W-1:1]}, and drive `rf_lo_out` = F[0] with `rf_lo_oe` high.
- R6: Codes 4 and 5 drive `q_lo_out` = Q[0] with `q_lo_oe` high. On code 4, Q becomes {`q_hi_in`, Q[W-1:1]} at the edge. On code 5, Q holds.
- R7: Codes 6 and 7 raise `rf_we` with `rf_wdata` = {F[W-2:0], `rf_lo_in`}, and drive `rf_hi_out` = F[W-1] with `rf_hi_oe` high.
- R8: Codes 6 and 7 drive `q_hi_out` = Q[W-1] with `q_hi_oe` high. On code 6, Q becomes {Q[W-2:0], `q_lo_in`} at the edge. On code 7, Q holds.
- R9: In codes 0 to 3, all four output enables are low and all four output values are 0. The four shift inputs have no effect on `rf_wdata`, Y or the next Q.
- R10: Q changes only on a rising clock edge where `q_load` is high, and then it takes `q_next`. `q_load` is high only for codes 0, 4 and 6.
- R11: When `rst` is high at a rising edge, Q is cleared to 0, even if a load is requested in that cycle.
- R12: Y equals F for every code except 2.
- R13: The enables depend only on the code. The pattern {`rf_lo_oe`,`rf_hi_oe`,`q_lo_oe`,`q_hi_oe`} is 1010 for codes 4 and 5, 0101 for codes 6 and 7, and 0000 otherwise. A shifter never enables both of its ends at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; Q updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset of Q |
| code | input | 3 | Destination code |
| f | input | W | ALU result |
| a_latch | input | W | A-port latch value, used as Y for code 2 |
| rf_lo_in | input | 1 | Register shifter LSB-end input |
| rf_hi_in | input | 1 | Register shifter MSB-end input |
| q_lo_in | input | 1 | Q shifter LSB-end input |
| q_hi_in | input | 1 | Q shifter MSB-end input |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | W | Register-file write data |
| q_load | output | 1 | Q load enable |
| q_next | output | W | Value that Q takes when loaded |
| q | output | W | Current Q register |
| y | output | W | Y bus |
| rf_lo_out | output | 1 | Register shifter LSB-end output value |
| rf_lo_oe | output | 1 | Register shifter LSB-end output enable |
| rf_hi_out | output | 1 | Register shifter MSB-end output value |
| rf_hi_oe | output | 1 | Register shifter MSB-end output enable |
| q_lo_out | output | 1 | Q shifter LSB-end output value |
| q_lo_oe | output | 1 | Q shifter LSB-end output enable |
| q_hi_out | output | 1 | Q shifter MSB-end output value |
| q_hi_oe | output | 1 | Q shifter MSB-end output enable |

## Verification
The hardest case to reach from the ports is a Q shift from an arbitrary known Q value, because Q cannot be written directly. Before every trial, the stimulus first spends one cycle on code 0 with F set to the wanted Q. It then applies the code under test with F, the A latch and the four shift inputs all varied. Every code is swept against all sixteen Q values and all sixteen F values. The shift inputs are derived from the data, so each end bit is seen at both levels while the ports are meant to be ignored.

// File: rtl/dst_pkg.sv
package dst_pkg;

  typedef enum logic [2:0] {
    DST_Q_F    = 3'd0,
    DST_NONE   = 3'd1,
    DST_RF_YA  = 3'd2,
    DST_RF_F   = 3'd3,
    DST_DN_RQ  = 3'd4,
    DST_DN_R   = 3'd5,
    DST_UP_RQ  = 3'd6,
    DST_UP_R   = 3'd7
  } dst_code_e;

  typedef struct packed {
    logic rf_we;
    logic q_load;
    logic q_from_shift;
    logic y_from_a;
    logic dn;
    logic up;
  } dst_ctrl_t;

endpackage

// File: rtl/dst_decode.sv
module dst_decode
  import dst_pkg::*;
(
  input  logic [2:0] code,
  output dst_ctrl_t  ctl
);
  always_comb begin
    ctl = '0;
    unique case (dst_code_e'(code))
      DST_Q_F:   ctl.q_load = 1'b1;
      DST_NONE:  ;
      DST_RF_YA: begin ctl.rf_we = 1'b1; ctl.y_from_a = 1'b1; end
      DST_RF_F:  ctl.rf_we = 1'b1;
      DST_DN_RQ: begin ctl.rf_we = 1'b1; ctl.dn = 1'b1; ctl.q_load = 1'b1; ctl.q_from_shift = 1'b1; end
      DST_DN_R:  begin ctl.rf_we = 1'b1; ctl.dn = 1'b1; end
      DST_UP_RQ: begin ctl.rf_we = 1'b1; ctl.up = 1'b1; ctl.q_load = 1'b1; ctl.q_from_shift = 1'b1; end
      DST_UP_R:  begin ctl.rf_we = 1'b1; ctl.up = 1'b1; end
      default:   ctl = '0;
    endcase
  end
endmodule

// File: rtl/dst_shifter.sv
module dst_shifter #(
  parameter int W = 4
) (
  input  logic         dn,
  input  logic         up,
  input  logic [W-1:0] val,
  input  logic         lo_in,
  input  logic         hi_in,
  output logic [W-1:0] shifted,
  output logic         lo_out,
  output logic         lo_oe,
  output logic         hi_out,
  output logic         hi_oe
);
  function automatic logic [W-1:0] toward_lsb(input logic [W-1:0] v, input logic fill);
    return {fill, v[W-1:1]};
  endfunction

  function automatic logic [W-1:0] toward_msb(input logic [W-1:0] v, input logic fill);
    return {v[W-2:0], fill};
  endfunction

  always_comb begin
    if (dn)      shifted = toward_lsb(val, hi_in);
    else if (up) shifted = toward_msb(val, lo_in);
    else         shifted = val;
  end

  assign lo_oe  = dn;
  assign hi_oe  = up;
  assign lo_out = dn & val[0];
  assign hi_out = up & val[W-1];
endmodule

// File: rtl/dst_qreg.sv
module dst_qreg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/dst_shift_ctrl.sv
module dst_shift_ctrl
  import dst_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   code,
  input  logic [W-1:0] f,
  input  logic [W-1:0] a_latch,
  input  logic         rf_lo_in,
  input  logic         rf_hi_in,
  input  logic         q_lo_in,
  input  logic         q_hi_in,
  output logic         rf_we,
  output logic [W-1:0] rf_wdata,
  output logic         q_load,
  output logic [W-1:0] q_next,
  output logic [W-1:0] q,
  output logic [W-1:0] y,
  output logic         rf_lo_out,
  output logic         rf_lo_oe,
  output logic         rf_hi_out,
  output logic         rf_hi_oe,
  output logic         q_lo_out,
  output logic         q_lo_oe,
  output logic         q_hi_out,
  output logic         q_hi_oe
);
  localparam int LANES = 2;  // lane 0: register-file path, lane 1: Q path

  dst_ctrl_t ctl;
  logic      shift_dn, shift_up;

  dst_decode u_dec (.code(code), .ctl(ctl));

  assign shift_dn = ctl.dn;
  assign shift_up = ctl.up;

  logic [W-1:0] lane_val [LANES];
  logic [W-1:0] lane_sh  [LANES];
  logic [LANES-1:0] lane_lo_in, lane_hi_in, lane_lo_out, lane_lo_oe, lane_hi_out, lane_hi_oe;

  assign lane_val[0] = f;
  assign lane_val[1] = q;
  assign lane_lo_in  = {q_lo_in, rf_lo_in};
  assign lane_hi_in  = {q_hi_in, rf_hi_in};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dst_shifter #(.W(W)) u_sh (
      .dn(shift_dn), .up(shift_up), .val(lane_val[g]),
      .lo_in(lane_lo_in[g]), .hi_in(lane_hi_in[g]),
      .shifted(lane_sh[g]),
      .lo_out(lane_lo_out[g]), .lo_oe(lane_lo_oe[g]),
      .hi_out(lane_hi_out[g]), .hi_oe(lane_hi_oe[g])
    );
  end

  assign rf_we     = ctl.rf_we;
  assign rf_wdata  = lane_sh[0];
  assign q_load    = ctl.q_load;
  assign q_next    = ctl.q_from_shift ? lane_sh[1] : f;
  assign y         = ctl.y_from_a ? a_latch : f;

  assign rf_lo_out = lane_lo_out[0];
  assign rf_lo_oe  = lane_lo_oe[0];
  assign rf_hi_out = lane_hi_out[0];
  assign rf_hi_oe  = lane_hi_oe[0];
  assign q_lo_out  = lane_lo_out[1];
  assign q_lo_oe   = lane_lo_oe[1];
  assign q_hi_out  = lane_hi_out[1];
  assign q_hi_oe   = lane_hi_oe[1];

  dst_qreg #(.W(W)) u_q (.clk(clk), .rst(rst), .load(q_load), .d(q_next), .q(q));
endmodule

// File: rtl/dst_shift_ctrl_chk.sv
module dst_shift_ctrl_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   code,
  input logic [W-1:0] f,
  input logic [W-1:0] y,
  input logic [W-1:0] q,
  input logic [W-1:0] q_next,
  input logic         q_load,
  input logic         rf_we,
  input logic         rf_lo_oe,
  input logic         rf_hi_oe,
  input logic         q_lo_oe,
  input logic         q_hi_oe,
  input logic         shift_dn,
  input logic         shift_up
);
  AST_PORTS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (code < 3'd4) |-> !(rf_lo_oe || rf_hi_oe || q_lo_oe || q_hi_oe)); // R9
  AST_Q_HOLD: assert property (@(posedge clk) disable iff (rst)
    !q_load |=> $stable(q)); // R10
  AST_Q_TAKE: assert property (@(posedge clk) disable iff (rst)
    q_load |=> q == $past(q_next)); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> q == '0); // R11
  AST_Y_PASS: assert property (@(posedge clk) disable iff (rst)
    (code != 3'd2) |-> y == f); // R12
  AST_ONE_END: assert property (@(posedge clk) disable iff (rst)
    !(rf_lo_oe && rf_hi_oe) && !(q_lo_oe && q_hi_oe)); // R13
  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $countones({shift_dn, shift_up}) <= 1); // R13
  AST_NO_WRITE_LOW: assert property (@(posedge clk) disable iff (rst)
    (code == 3'd0 || code == 3'd1) |-> !rf_we); // R1
endmodule

bind dst_shift_ctrl dst_shift_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .code(code), .f(f), .y(y), .q(q), .q_next(q_next),
  .q_load(q_load), .rf_we(rf_we), .rf_lo_oe(rf_lo_oe), .rf_hi_oe(rf_hi_oe),
  .q_lo_oe(q_lo_oe), .q_hi_oe(q_hi_oe), .shift_dn(shift_dn), .shift_up(shift_up)
);

// File: tb/dst_shift_ctrl_bench.sv
`timescale 1ns/1ps
module dst_shift_ctrl_bench;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] code = '0;
  logic [W-1:0] f = '0, a_latch = '0;
  logic rf_lo_in = 0, rf_hi_in = 0, q_lo_in = 0, q_hi_in = 0;
  logic rf_we, q_load, rf_lo_out, rf_lo_oe, rf_hi_out, rf_hi_oe;
  logic q_lo_out, q_lo_oe, q_hi_out, q_hi_oe;
  logic [W-1:0] rf_wdata, q_next, q, y;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dst_shift_ctrl #(.W(W)) u_dst_shift_ctrl (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (code %0d f %0h)", req, act, exp, code, f);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int ex_y, ex_wd, ex_q, ex_oe, ex_out;
    bit ex_we, ex_ld;
    string rq;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(q == 0, "R11 reset clears Q", q, 0);
    code = 3'd1;
    #1;
    check({rf_lo_oe, rf_hi_oe, q_lo_oe, q_hi_oe} == 0, "R13 no enable after reset", 0, 0);
    rst = 1'b0;
    // load a value, then reset while loading: reset wins (R11)
    code = 3'd0; f = 4'h9;
    @(negedge clk);
    check(q == 4'h9, "R1 code 0 loads Q", q, 9);
    rst = 1'b1; f = 4'h6;
    @(negedge clk);
    check(q == 0, "R11 reset beats load", q, 0);
    rst = 1'b0;

    for (int c = 0; c < 8; c++) begin
      for (int qv = 0; qv < 16; qv++) begin
        for (int fv = 0; fv < 16; fv++) begin
          code = 3'd0; f = qv[W-1:0];
          @(negedge clk);
          code = c[2:0]; f = fv[W-1:0]; a_latch = 4'(~fv ^ qv);
          rf_lo_in = fv[0] ^ qv[1]; rf_hi_in = fv[3] ^ qv[0];
          q_lo_in  = fv[1] ^ qv[3]; q_hi_in  = fv[2] ^ qv[2];
          // expectations from the requirements
          ex_we  = (c >= 2);
          ex_ld  = (c == 0 || c == 4 || c == 6);
          ex_y   = (c == 2) ? int'(a_latch) : fv;
          ex_q   = qv;
          ex_oe  = 0; ex_out = 0; ex_wd = fv;
          rq = (c == 0) ? "R1" : (c == 1) ? "R2" : (c == 2) ? "R3" : (c == 3) ? "R4" : "R9";
          if (c == 0) ex_q = fv;
          if (c == 4 || c == 5) begin
            ex_wd  = (fv / 2) + (rf_hi_in ? 8 : 0);
            ex_oe  = 4'b1010;
            ex_out = ((fv % 2) * 8) + ((qv % 2) * 2);
            if (c == 4) ex_q = (qv / 2) + (q_hi_in ? 8 : 0);
          end
          if (c == 6 || c == 7) begin
            ex_wd  = ((fv * 2) % 16) + (rf_lo_in ? 1 : 0);
            ex_oe  = 4'b0101;
            ex_out = ((fv / 8) * 4) + (qv / 8);
            if (c == 6) ex_q = ((qv * 2) % 16) + (q_lo_in ? 1 : 0);
          end
          #1;
          check(y == ex_y[W-1:0], (c == 2) ? "R3 Y shows A latch" : "R12 Y shows F", y, ex_y);
          check(rf_we == ex_we, (c < 2) ? "R1 R2 write enable" : "R3 R4 R5 R7 write enable", rf_we, ex_we);
          if (ex_we)
            check(rf_wdata == ex_wd[W-1:0], (c >= 6) ? "R7 up write data" : (c >= 4) ? "R5 down write data" : "R9 plain write data", rf_wdata, ex_wd);
          check(q_load == ex_ld, "R10 load enable by code", q_load, ex_ld);
          check({rf_lo_oe, rf_hi_oe, q_lo_oe, q_hi_oe} == ex_oe[3:0], "R13 enable pattern", {rf_lo_oe, rf_hi_oe, q_lo_oe, q_hi_oe}, ex_oe);
          check({rf_lo_out, rf_hi_out, q_lo_out, q_hi_out} == ex_out[3:0], (c >= 4) ? "R6 R8 port outputs" : "R9 idle port outputs", {rf_lo_out, rf_hi_out, q_lo_out, q_hi_out}, ex_out);
          @(negedge clk);
          check(q == ex_q[W-1:0], (c == 4 || c == 5) ? "R6 Q down or hold" : (c >= 6) ? "R8 Q up or hold" : (c == 0) ? "R1 Q load" : {rq, " R10 Q hold"}, q, ex_q);
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule